// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This block gives one processor tile its machine-level timer and software interrupts. It keeps a 64-bit real-time counter that advances once every eight core clocks, a 64-bit compare value and a single software-interrupt pending bit. These registers are reached through a simple register bus. A request is presented for one cycle with a valid strobe, a write enable, a 20-bit byte offset and 64 bits of write data. The block answers every request exactly one cycle later.

The machine timer interrupt line is high whenever the counter is strictly above the compare value. The machine software interrupt line follows the pending bit. Software can reach the pending bit through two offsets that alias the same state. Firmware sets a deadline by writing the compare value. It clears the timer interrupt by moving the compare value forward. It raises or lowers the software interrupt by writing bit 0 of either alias.

Top module: `core_timer_irq`

## Requirements
- R1: A write to offset 0x00000 loads req_wdata bit 0 into the software pending bit. irq_soft shows the new value from the cycle after the write, and the upper 63 data bits are ignored.
- R2: Offset 0x0B000 aliases the same pending bit. A write there has the same effect as R1, and a read from either offset returns the bit in data bit 0 with all other bits zero.
- R3: The counter, read at offset 0x0BFF8, starts at zero. It increases by exactly one on every eighth rising clock edge after reset is released, with the first increment on the eighth edge, and it wraps from all ones to zero.
- R4: The compare register at offset 0x04000 resets to all ones and returns on a read the last 64-bit value written.
- R5: irq_timer is high exactly when the counter, read as unsigned, is strictly greater than the compare value, and it reflects a write to either register from the cycle after that write.
- R6: A write to the counter loads the written value. If an increment falls due in the same cycle, the increment is dropped, and the eight-cycle cadence of later increments is unchanged.
- R7: A read from any other offset returns zero. A write to any other offset changes no register.
- R8: Every cycle with req_valid high produces resp_valid high on the next cycle, and resp_valid is low otherwise. resp_rdata carries the read value for a read, and it is zero after a write or when there is no response.
- R9: While rst_n is low at a rising edge, the block clears resp_valid, irq_soft, the counter and its eight-cycle phase, and sets the compare value to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte offset inside the device |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_rdata | output | 64 | Read data, zero for writes |
| irq_timer | output | 1 | Machine timer interrupt |
| irq_soft | output | 1 | Machine software interrupt |

## Verification
The assertions assume that the bus never holds a request waiting. Every valid cycle is a new, complete transaction, and the offset is known whenever req_valid is high. The bench drives every input on the falling edge and keeps req_valid low whenever it is not issuing a request, so the one-cycle response rule and the write-effect rules apply to each cycle on its own. Counter writes with random data and deliberate writes on the cycle an increment falls due keep these checks to well-defined single-cycle events.

// File: rtl/ctimer_pkg.sv
// Shared definitions for the core-local timer unit.
// Assumes: one register select per cycle, produced by the address decoder.
package ctimer_pkg;

    // Which register a bus request addresses
    typedef enum logic [2:0] {
        SEL_NONE       = 3'd0,
        SEL_SOFT       = 3'd1,
        SEL_SOFT_ALIAS = 3'd2,
        SEL_CMP        = 3'd3,
        SEL_CNT        = 3'd4
    } ctimer_sel_e;

endpackage

// File: rtl/ctimer_decode.sv
// Address decoder: maps a byte offset onto one register select.
// Assumes offsets are compared exactly; anything else selects nothing.
module ctimer_decode
    import ctimer_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter logic [ADDR_W-1:0] OFF_SOFT  = 'h00000,
    parameter logic [ADDR_W-1:0] OFF_ALIAS = 'h0B000,
    parameter logic [ADDR_W-1:0] OFF_CMP   = 'h04000,
    parameter logic [ADDR_W-1:0] OFF_CNT   = 'h0BFF8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output ctimer_sel_e       sel_o
);

    // Exact-match compare of the offset against each register location
    always_comb begin
        if (addr_i == OFF_SOFT)       sel_o = SEL_SOFT;
        else if (addr_i == OFF_ALIAS) sel_o = SEL_SOFT_ALIAS;
        else if (addr_i == OFF_CMP)   sel_o = SEL_CMP;
        else if (addr_i == OFF_CNT)   sel_o = SEL_CNT;
        else                          sel_o = SEL_NONE;
    end

endmodule

// File: rtl/ctimer_rtc.sv
// Real-time counter with a clock prescaler.
// The counter advances when the prescaler wraps, which is every 2**PRESCALE_W
// clocks. A write takes priority over an increment that is due in the same
// cycle. The prescaler phase is never disturbed by a write.
// Assumes synchronous active-low reset.
module ctimer_rtc #(
    parameter int DATA_W     = 64,
    parameter int PRESCALE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] count_o
);

    logic              tick;
    logic [DATA_W-1:0] count_q;

    generate
        if (PRESCALE_W > 0) begin : g_prescale
            logic [PRESCALE_W-1:0] pre_q;

            // Free-running prescaler that sets the increment cadence
            always_ff @(posedge clk) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_q + 1'b1;
            end

            assign tick = &pre_q;
        end else begin : g_direct
            assign tick = 1'b1;
        end
    endgenerate

    // Counter register: a write wins, otherwise step on a prescaler wrap
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (wr_en_i) count_q <= wr_data_i;
        else if (tick)    count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

endmodule

// File: rtl/ctimer_cmp.sv
// Timer compare register and timer interrupt generation.
// The interrupt is a pure compare of the two registers, so a write to
// either one shows on the line from the following cycle.
// Assumes synchronous active-low reset; resets to all ones (no interrupt).
module ctimer_cmp #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [DATA_W-1:0] count_i,
    output logic [DATA_W-1:0] cmp_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] cmp_q;

    // Compare value register, loaded by software
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_q <= '1;
        else if (wr_en_i) cmp_q <= wr_data_i;
    end

    // Strict unsigned greater-than raises the timer interrupt
    always_comb begin
        irq_o = (count_i > cmp_q);
    end

    assign cmp_o = cmp_q;

endmodule

// File: rtl/ctimer_soft.sv
// Software interrupt pending bit.
// Assumes the caller has already merged both alias offsets into one enable.
module ctimer_soft (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic wr_bit_i,
    output logic pend_o
);

    logic pend_q;

    // Pending bit follows written data bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (wr_en_i) pend_q <= wr_bit_i;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/core_timer_irq.sv
// Core-local timer and software interrupt unit, top level.
// Decodes single-cycle register requests and updates the counter, compare
// and pending-bit registers. Every request gets a registered response one
// cycle later. Read data is the register value before this cycle's edge.
// Assumes no back-pressure on the response and synchronous active-low reset.
module core_timer_irq
    import ctimer_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 64,
    parameter int PRESCALE_W = 3,
    parameter logic [ADDR_W-1:0] OFF_SOFT  = 'h00000,
    parameter logic [ADDR_W-1:0] OFF_ALIAS = 'h0B000,
    parameter logic [ADDR_W-1:0] OFF_CMP   = 'h04000,
    parameter logic [ADDR_W-1:0] OFF_CNT   = 'h0BFF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              irq_timer,
    output logic              irq_soft
);

    ctimer_sel_e       sel;
    logic              wr_any;
    logic              rd_any;
    logic              wr_soft;
    logic              wr_cmp;
    logic              wr_cnt;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] cmp_q;
    logic              pend_q;
    logic [DATA_W-1:0] rd_mux;
    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_rdata_q;

    ctimer_decode #(
        .ADDR_W    (ADDR_W),
        .OFF_SOFT  (OFF_SOFT),
        .OFF_ALIAS (OFF_ALIAS),
        .OFF_CMP   (OFF_CMP),
        .OFF_CNT   (OFF_CNT)
    ) decode_i (
        .addr_i (req_addr),
        .sel_o  (sel)
    );

    // Split the request into per-register write strobes
    always_comb begin
        wr_any  = req_valid && req_we;
        rd_any  = req_valid && !req_we;
        wr_soft = wr_any && ((sel == SEL_SOFT) || (sel == SEL_SOFT_ALIAS));
        wr_cmp  = wr_any && (sel == SEL_CMP);
        wr_cnt  = wr_any && (sel == SEL_CNT);
    end

    ctimer_rtc #(
        .DATA_W     (DATA_W),
        .PRESCALE_W (PRESCALE_W)
    ) rtc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_cnt),
        .wr_data_i (req_wdata),
        .count_o   (count_q)
    );

    ctimer_cmp #(
        .DATA_W (DATA_W)
    ) cmp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_cmp),
        .wr_data_i (req_wdata),
        .count_i   (count_q),
        .cmp_o     (cmp_q),
        .irq_o     (irq_timer)
    );

    ctimer_soft soft_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_soft),
        .wr_bit_i (req_wdata[0]),
        .pend_o   (pend_q)
    );

    // Read data selection; unmapped offsets read as zero
    always_comb begin
        case (sel)
            SEL_SOFT, SEL_SOFT_ALIAS: rd_mux = {{(DATA_W-1){1'b0}}, pend_q};
            SEL_CMP:                  rd_mux = cmp_q;
            SEL_CNT:                  rd_mux = count_q;
            default:                  rd_mux = '0;
        endcase
    end

    // Registered response: one cycle after every request, data only on reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q <= 1'b0;
            resp_rdata_q <= '0;
        end else begin
            resp_valid_q <= req_valid;
            resp_rdata_q <= rd_any ? rd_mux : '0;
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_rdata = resp_rdata_q;
    assign irq_soft   = pend_q;

endmodule

// File: rtl/ctimer_chk.sv
// Protocol and register-update checker for the timer unit, bound to the top.
// Assumes every valid cycle is an independent request.
module ctimer_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 64,
    parameter logic [ADDR_W-1:0] OFF_SOFT  = 'h00000,
    parameter logic [ADDR_W-1:0] OFF_ALIAS = 'h0B000,
    parameter logic [ADDR_W-1:0] OFF_CMP   = 'h04000,
    parameter logic [ADDR_W-1:0] OFF_CNT   = 'h0BFF8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic              wbit0,
    input logic              resp_valid,
    input logic [DATA_W-1:0] resp_rdata,
    input logic              irq_soft,
    input logic [DATA_W-1:0] count_q
);

    logic hit_soft;
    logic hit_cnt;
    logic hit_none;

    // Independent offset classification for the properties
    always_comb begin
        hit_soft = (req_addr == OFF_SOFT) || (req_addr == OFF_ALIAS);
        hit_cnt  = (req_addr == OFF_CNT);
        hit_none = !hit_soft && !hit_cnt && (req_addr != OFF_CMP);
    end

    // R8
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R8
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    // R1
    soft_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && hit_soft) |=> (irq_soft == $past(wbit0)));

    // R7
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && hit_none) |=> $stable(irq_soft));

    // R7
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && hit_none) |=> (resp_rdata == '0));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_we && hit_cnt) |=>
            ((count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!resp_valid && !irq_soft && (count_q == '0)));

endmodule

bind core_timer_irq ctimer_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .OFF_SOFT  (OFF_SOFT),
    .OFF_ALIAS (OFF_ALIAS),
    .OFF_CMP   (OFF_CMP),
    .OFF_CNT   (OFF_CNT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .wbit0      (req_wdata[0]),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata),
    .irq_soft   (irq_soft),
    .count_q    (count_q)
);

// File: tb/core_timer_irq_tb.sv
// Bench: behavioural reference model compared against the unit every clock.
module core_timer_irq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        resp_valid;
    logic [63:0] resp_rdata;
    logic        irq_timer;
    logic        irq_soft;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    bit [63:0] m_cnt = '0;
    bit [63:0] m_cmp = '1;
    bit [63:0] m_rd  = '0;
    bit        m_sip = 0;
    bit        m_rv  = 0;
    int        m_pre = 0;

    always #4 clk = ~clk;

    core_timer_irq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata),
        .irq_timer  (irq_timer),
        .irq_soft   (irq_soft)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk({63'b0, resp_valid}, {63'b0, m_rv}, "R8 resp_valid");
        chk(resp_rdata, m_rd, "R8 resp_rdata");
        chk({63'b0, irq_soft}, {63'b0, m_sip}, "R1 irq_soft");
        chk({63'b0, irq_timer}, {63'b0, (m_cnt > m_cmp)}, "R5 irq_timer");
    endtask

    // Advance the model over the coming edge using the inputs now driven
    task automatic model_step();
        bit tick;
        if (!rst_n) begin
            m_cnt = '0; m_cmp = '1; m_sip = 0; m_rv = 0; m_rd = '0; m_pre = 0;
        end else begin
            m_rv = req_valid;
            m_rd = '0;
            if (req_valid && !req_we) begin
                case (req_addr)
                    20'h00000, 20'h0B000: m_rd = {63'b0, m_sip};
                    20'h04000:            m_rd = m_cmp;
                    20'h0BFF8:            m_rd = m_cnt;
                    default:              m_rd = '0;
                endcase
            end
            tick  = (m_pre == 7);
            m_pre = (m_pre + 1) % 8;
            if (req_valid && req_we && req_addr == 20'h0BFF8) m_cnt = req_wdata;
            else if (tick) m_cnt = m_cnt + 64'd1;
            if (req_valid && req_we && req_addr == 20'h04000) m_cmp = req_wdata;
            if (req_valid && req_we && (req_addr == 20'h00000 || req_addr == 20'h0B000))
                m_sip = req_wdata[0];
        end
    endtask

    task automatic cyc(input bit v, input bit we, input logic [19:0] a, input logic [63:0] d);
        @(negedge clk);
        compare_all();
        req_valid = v; req_we = we; req_addr = a; req_wdata = d;
        model_step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, '0);
    endtask

    task automatic rd_expect(input logic [19:0] a, input logic [63:0] exp, input string req);
        cyc(1, 0, a, '0);
        cyc(0, 0, '0, '0);
        chk(resp_rdata, exp, req);
    endtask

    initial begin
        rst_n = 1'b0;
        idle(3);
        // R9 reset state
        chk({62'b0, irq_soft, resp_valid}, 64'd0, "R9 reset outputs");
        @(negedge clk); rst_n = 1'b1;
        model_step();
        // R3 counter zero just after reset, first step on the eighth edge
        rd_expect(20'h0BFF8, 64'd0, "R3 counter at start");
        idle(5);
        rd_expect(20'h0BFF8, 64'd1, "R3 first increment");
        // R4 compare resets to all ones
        rd_expect(20'h04000, '1, "R4 compare reset");
        // R1 / R2 soft bit and alias
        cyc(1, 1, 20'h00000, 64'h1);
        cyc(0, 0, '0, '0);
        chk({63'b0, irq_soft}, 64'd1, "R1 soft set");
        rd_expect(20'h0B000, 64'd1, "R2 alias read");
        cyc(1, 1, 20'h0B000, 64'hFFFF_FFFF_FFFF_FFFE);
        rd_expect(20'h00000, 64'd0, "R2 alias clear, R1 upper bits ignored");
        // R7 unmapped access
        cyc(1, 1, 20'h04008, 64'h5);
        cyc(1, 1, 20'h00004, 64'h1);
        rd_expect(20'h04000, '1, "R7 compare untouched");
        rd_expect(20'h00000, 64'd0, "R7 soft untouched");
        rd_expect(20'h12345, 64'd0, "R7 unmapped read zero");
        // R4 / R5 compare written low raises the timer interrupt
        cyc(1, 1, 20'h04000, 64'd3);
        rd_expect(20'h04000, 64'd3, "R4 compare readback");
        idle(40);
        chk({63'b0, irq_timer}, 64'd1, "R5 timer raised");
        cyc(1, 1, 20'h04000, 64'hFFFF);
        cyc(0, 0, '0, '0);
        chk({63'b0, irq_timer}, 64'd0, "R5 timer cleared next cycle");
        // R6 write on the cycle an increment is due
        for (int k = 0; k < 8 && m_pre != 7; k++) cyc(0, 0, '0, '0);
        cyc(1, 1, 20'h0BFF8, 64'd500);
        rd_expect(20'h0BFF8, 64'd500, "R6 write beats increment");
        // R3 wrap and R5 strict compare
        cyc(1, 1, 20'h04000, 64'hFFFF_FFFF_FFFF_FFFE);
        cyc(1, 1, 20'h0BFF8, 64'hFFFF_FFFF_FFFF_FFFE);
        cyc(0, 0, '0, '0);
        chk({63'b0, irq_timer}, 64'd0, "R5 equal gives no interrupt");
        idle(20);
        // random mix, compared against the model every clock
        for (int i = 0; i < 3000; i++) begin
            logic [19:0] a;
            int sel = $urandom % 7;
            case (sel)
                0: a = 20'h00000; 1: a = 20'h0B000; 2: a = 20'h04000;
                3: a = 20'h0BFF8; 4: a = 20'h0BFF0; 5: a = 20'h04004;
                default: a = 20'h00008;
            endcase
            if ($urandom % 3 == 0) cyc(0, 0, '0, '0);
            else cyc(1, ($urandom % 2) == 1, a, {56'b0, 8'($urandom)});
        end
        // R9 reset in mid-run
        cyc(1, 1, 20'h00000, 64'h1);
        @(negedge clk); compare_all(); rst_n = 1'b0; req_valid = 0; model_step();
        cyc(0, 0, '0, '0);
        rst_n = 1'b1; model_step();
        rd_expect(20'h04000, '1, "R9 compare back to all ones");
        idle(4);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule